// File: doc/BRIEF.md
# Fractional Clock-Enable Divider

This block turns a fast input clock into a periodic one-cycle enable pulse whose average spacing is a rational number of input cycles. Every output period lasts either a base count of input cycles or one cycle more. A short repeating bit pattern chooses which periods are stretched. With a pattern of L+1 entries, holding S set bits, the block produces L+1 pulses in exactly (L+1)·base + S input cycles. A downstream phase-locked loop can therefore use the pulse as its reference or feedback enable, and this allows reference rates that an integer divider cannot reach.

Software sets three values: the base divisor, the pattern length (stored as the entry count minus one) and the pattern bits. When the length field is zero the block is a plain integer divider. The block reads all three values only at the start of a complete pattern pass. A change made in the middle of a pass therefore never produces a period of the wrong length. A base divisor below 2 is raised to 2, so the output is always a pulse and never a constant level.

The controller is a three-state machine:
- ST_LOAD: entered from reset. It captures the settings, then moves to ST_COUNT.
- ST_COUNT: counts the base cycles of a period. At the last base cycle it moves to ST_STRETCH if the current pattern entry is set. Otherwise the period ends there and the machine stays in ST_COUNT.
- ST_STRETCH: the single extra cycle. It ends the period and returns to ST_COUNT.

When the last entry of a pass ends its period, the settings are captured again.

Top module: `frac_clk_div`

## Requirements
- R1: While reset is low, tick_o is 0. After reset is released, the settings are sampled at the first rising edge. If the first period is P cycles long, the first tick_o pulse is high in the cycle after rising edge P+1. A reset in mid-run restarts this sequence.
- R2: tick_o is high for exactly one input cycle per period. Consecutive pulses are separated by the length of the period that ends with the second pulse.
- R3: With a sequence-length field of 0, every period is max(divisor, 2) cycles and the pattern bits have no effect. For example, divisor 8 gives 10 pulses in any 80 consecutive cycles.
- R4: A divisor value of 0 or 1 behaves exactly like a divisor of 2.
- R5: With a length field L ≥ 1, the periods follow entry k = 0, 1, … L in order and then wrap to 0. Entry k uses bit position k of the pattern, and gives divisor+1 cycles when the bit is 1 and divisor cycles when it is 0.
- R6: Pattern bits at positions above L have no effect on any period.
- R7: The divisor, length and pattern are sampled only at the rising edge that ends the last period of a pass, and at the first edge after reset. A change at any other time first applies to the pass that begins after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| div_int_i | input | DIV_W (7) | Integer base divisor |
| seq_len_i | input | LEN_W (3) | Pattern entry count minus one; 0 selects plain integer division |
| seq_pat_i | input | 2**LEN_W (8) | Stretch pattern; bit k stretches period k |
| tick_o | output | 1 | One-cycle pulse at the end of each period |

## Verification
The bench builds the block with its default parameters: a 7-bit divisor, a 3-bit length field and an 8-bit pattern. These defaults cover the full 8-entry pattern, the largest divisor (127, stretched to 128) and the clamped divisors 0 and 1. A behavioural model builds a queue of period lengths whenever a pass begins. The bench compares tick_o against this model on every cycle, including the cycles in which the settings change in the middle of a pass, so it exercises the rule that settings are captured only at a pass boundary. Pulse counts over fixed windows confirm the average ratio for the integer setting and for the fractional setting.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_STRETCH = 2'd2
    } fdiv_state_e;

    localparam int unsigned MIN_DIV = 2;

endpackage

// File: rtl/frac_div_cfg.sv
module frac_div_cfg #(
    parameter int unsigned DIV_W = 7,
    parameter int unsigned LEN_W = 3
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   load_i,
    input  logic [DIV_W-1:0]       div_i,
    input  logic [LEN_W-1:0]       len_i,
    input  logic [(1<<LEN_W)-1:0]  pat_i,
    output logic [DIV_W-1:0]       div_o,
    output logic [LEN_W-1:0]       len_o,
    output logic [(1<<LEN_W)-1:0]  pat_o
);
    import frac_div_pkg::*;

    localparam int unsigned PAT_W = 1 << LEN_W;
    localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_DIV);

    logic [DIV_W-1:0] div_clamped;
    logic [PAT_W-1:0] pat_masked;

    assign div_clamped = (div_i < DIV_FLOOR) ? DIV_FLOOR : div_i;

    // Keep only entries 0..len; a zero length disables stretching entirely.
    for (genvar k = 0; k < PAT_W; k++) begin : g_mask
        assign pat_masked[k] = pat_i[k] && (len_i != '0) && (LEN_W'(k) <= len_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            div_o <= DIV_FLOOR;
            len_o <= '0;
            pat_o <= '0;
        end else if (load_i) begin
            div_o <= div_clamped;
            len_o <= len_i;
            pat_o <= pat_masked;
        end
    end

endmodule

// File: rtl/frac_div_seq_fsm.sv
module frac_div_seq_fsm #(
    parameter int unsigned DIV_W = 7,
    parameter int unsigned LEN_W = 3
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [DIV_W-1:0]            div_i,
    input  logic [LEN_W-1:0]            len_i,
    input  logic [(1<<LEN_W)-1:0]       pat_i,
    output logic                        load_o,
    output logic                        end_o,
    output frac_div_pkg::fdiv_state_e   st_o,
    output logic [DIV_W-1:0]            cnt_o,
    output logic [LEN_W-1:0]            idx_o,
    output logic                        tick_o
);
    import frac_div_pkg::*;

    fdiv_state_e      st_q, st_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [LEN_W-1:0] idx_q, idx_d;
    logic [DIV_W-1:0] last_cnt;
    logic             end_p;
    logic             load;

    assign last_cnt = div_i - 1'b1;

    // State register with its counter and pattern index.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q  <= ST_LOAD;
            cnt_q <= '0;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            idx_q <= idx_d;
        end
    end

    // Next state and period bookkeeping.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        idx_d = idx_q;
        load  = 1'b0;
        end_p = 1'b0;
        unique case (st_q)
            ST_LOAD: begin
                load  = 1'b1;
                st_d  = ST_COUNT;
                cnt_d = '0;
                idx_d = '0;
            end
            ST_COUNT: begin
                if (cnt_q == last_cnt) begin
                    if (pat_i[idx_q]) begin
                        st_d = ST_STRETCH;
                    end else begin
                        end_p = 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_STRETCH: begin
                end_p = 1'b1;
            end
            default: begin
                st_d = ST_LOAD;
            end
        endcase
        if (end_p) begin
            st_d  = ST_COUNT;
            cnt_d = '0;
            if (idx_q == len_i) begin
                idx_d = '0;
                load  = 1'b1;
            end else begin
                idx_d = idx_q + 1'b1;
            end
        end
    end

    // Output register: pulse in the cycle after a period's final cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tick_o <= 1'b0;
        end else begin
            tick_o <= end_p;
        end
    end

    assign load_o = load;
    assign end_o  = end_p;
    assign st_o   = st_q;
    assign cnt_o  = cnt_q;
    assign idx_o  = idx_q;

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
    parameter int unsigned DIV_W = 7,
    parameter int unsigned LEN_W = 3
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [DIV_W-1:0]       div_int_i,
    input  logic [LEN_W-1:0]       seq_len_i,
    input  logic [(1<<LEN_W)-1:0]  seq_pat_i,
    output logic                   tick_o
);
    import frac_div_pkg::*;

    localparam int unsigned PAT_W = 1 << LEN_W;

    logic [DIV_W-1:0] div_act;
    logic [LEN_W-1:0] len_act;
    logic [PAT_W-1:0] pat_act;
    logic             cfg_load;
    logic             period_end;
    fdiv_state_e      fsm_st;
    logic [DIV_W-1:0] period_cnt;
    logic [LEN_W-1:0] seq_idx;

    frac_div_cfg #(
        .DIV_W (DIV_W),
        .LEN_W (LEN_W)
    ) u_cfg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (cfg_load),
        .div_i  (div_int_i),
        .len_i  (seq_len_i),
        .pat_i  (seq_pat_i),
        .div_o  (div_act),
        .len_o  (len_act),
        .pat_o  (pat_act)
    );

    frac_div_seq_fsm #(
        .DIV_W (DIV_W),
        .LEN_W (LEN_W)
    ) u_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .div_i  (div_act),
        .len_i  (len_act),
        .pat_i  (pat_act),
        .load_o (cfg_load),
        .end_o  (period_end),
        .st_o   (fsm_st),
        .cnt_o  (period_cnt),
        .idx_o  (seq_idx),
        .tick_o (tick_o)
    );

endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
    parameter int unsigned DIV_W = 7,
    parameter int unsigned LEN_W = 3
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic                      tick_o,
    input logic                      period_end,
    input frac_div_pkg::fdiv_state_e fsm_st,
    input logic [DIV_W-1:0]          period_cnt,
    input logic [LEN_W-1:0]          seq_idx,
    input logic [DIV_W-1:0]          div_act,
    input logic [LEN_W-1:0]          len_act
);
    import frac_div_pkg::*;

    // R1
    load_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_st == ST_LOAD) |=> !tick_o);

    // R2
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

    // R2
    stretch_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_st == ST_STRETCH) |=> (tick_o && fsm_st == ST_COUNT));

    // R4
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        period_cnt < div_act);

    // R4
    div_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_act >= DIV_W'(MIN_DIV));

    // R5
    idx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_idx <= len_act);

    // R7
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_st != ST_LOAD && !period_end) |=> ($stable(div_act) && $stable(len_act)));

endmodule

bind frac_clk_div frac_clk_div_chk #(
    .DIV_W (DIV_W),
    .LEN_W (LEN_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_o     (tick_o),
    .period_end (period_end),
    .fsm_st     (fsm_st),
    .period_cnt (period_cnt),
    .seq_idx    (seq_idx),
    .div_act    (div_act),
    .len_act    (len_act)
);

// File: tb/sim_frac_clk_div.sv
module sim_frac_clk_div;

    localparam int DIV_W = 7;
    localparam int LEN_W = 3;
    localparam int PAT_W = 1 << LEN_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_in = '0;
    logic [LEN_W-1:0] len_in = '0;
    logic [PAT_W-1:0] pat_in = '0;
    logic             tick;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    tick_cnt = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state
    int    per_q[$];
    int    remain = 0;
    bit    loaded = 1'b0;
    bit    exp_tick = 1'b0;

    always #2 clk = ~clk;

    frac_clk_div #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .div_int_i (div_in),
        .seq_len_i (len_in),
        .seq_pat_i (pat_in),
        .tick_o    (tick)
    );

    // Builds one pass worth of period lengths from the current settings.
    task automatic refill();
        int base;
        base = (int'(div_in) < 2) ? 2 : int'(div_in);
        if (len_in == 0) begin
            per_q.push_back(base);
        end else begin
            for (int k = 0; k <= int'(len_in); k++) begin
                per_q.push_back(base + (pat_in[k] ? 1 : 0));
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            loaded = 1'b0;
            exp_tick = 1'b0;
            per_q.delete();
        end else if (!loaded) begin
            loaded = 1'b1;
            refill();
            remain = per_q[0];
            exp_tick = 1'b0;
        end else begin
            remain = remain - 1;
            if (remain == 0) begin
                exp_tick = 1'b1;
                void'(per_q.pop_front());
                if (per_q.size() == 0) refill();
                remain = per_q[0];
            end else begin
                exp_tick = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            cyc++;
            n_cmp++;
            if (tick !== exp_tick) begin
                n_bad++;
                $display("FAIL %s cycle %0d tick_o actual %0b expected %0b",
                         cur_req, cyc, tick, exp_tick);
            end
            if (tick === 1'b1) tick_cnt++;
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_win(input string req, input int cycles, input int expect_n);
        int start;
        start = tick_cnt;
        run(cycles);
        n_cmp++;
        if (tick_cnt - start != expect_n) begin
            n_bad++;
            $display("FAIL %s pulses in %0d cycles actual %0d expected %0d",
                     req, cycles, tick_cnt - start, expect_n);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin
        // R1: reset holds tick low, first pulse after the first full period
        div_in = 7'd8; len_in = 3'd0; pat_in = 8'hFF;
        run(5);
        rst_n = 1'b1;
        run(30);
        // R3: integer divide by 8, pattern ignored (18.432 MHz -> 2.304 MHz case)
        cur_req = "R3";
        run(8);
        count_win("R3", 80, 10);
        // R4: divisors 1 and 0 behave as 2
        cur_req = "R4";
        div_in = 7'd1;
        run(20);
        count_win("R4", 40, 20);
        div_in = 7'd0;
        run(20);
        count_win("R4", 40, 20);
        // R5: three entries 1,0,1 with base 5 -> 6,5,6; upper bits set (R6)
        cur_req = "R5";
        div_in = 7'd5; len_in = 3'd2; pat_in = 8'b1111_1101;
        run(40);
        count_win("R5", 170, 30);
        // R6: two entries both clear, upper bits set -> all periods 5
        cur_req = "R6";
        len_in = 3'd1; pat_in = 8'b1111_1100;
        run(30);
        count_win("R6", 100, 20);
        // R5: full eight-entry pattern, base 4
        cur_req = "R5";
        div_in = 7'd4; len_in = 3'd7; pat_in = 8'b1000_0001;
        run(80);
        count_win("R5", 340, 80);
        // R7: changes inside a pass wait for the pass boundary
        cur_req = "R7";
        run(7);
        div_in = 7'd10; len_in = 3'd0; pat_in = 8'h00;
        run(3);
        div_in = 7'd3; len_in = 3'd3; pat_in = 8'b0000_0110;
        run(11);
        div_in = 7'd6;
        run(90);
        // R2: tightest and widest periods
        cur_req = "R2";
        div_in = 7'd2; len_in = 3'd0;
        run(40);
        div_in = 7'd127; len_in = 3'd1; pat_in = 8'b0000_0011;
        run(600);
        // R1: reset in mid-run restarts cleanly
        cur_req = "R1";
        div_in = 7'd9; len_in = 3'd0;
        run(5);
        rst_n = 1'b0;
        run(4);
        rst_n = 1'b1;
        run(40);
        finish_run();
    end

endmodule